// File: doc/BRIEF.md
# DMA Completion Response Queue

This block sits behind the data mover of a scatter-gather DMA engine and keeps a record of every finished descriptor. Each completion arrives as a valid/ready strobe that carries the byte count moved, an 8-bit error code, an early-termination flag and the control word of the descriptor that just finished. The block stores the byte count, the error code and the flag as one entry in a response FIFO. A host reads the entry back through a two-word window. Word 0 is the byte count and word 1 is the status.

The control word of the completing descriptor decides whether the completion raises the shared interrupt-pending flag. The flag can be raised by a completion request, by an early-termination request, or by an error code that overlaps a per-descriptor error mask. The interrupt line is the pending flag qualified by a global enable. Two optional halt conditions record that the dispatcher must stop, one on an error and one on an early termination. When the FIFO is full, the block withholds the data mover's ready until the host frees a slot.

Top module: `dma_resp_queue`

## Requirements
- R1: `cmp_ready` is low whenever the FIFO holds DEPTH entries. A completion is accepted only on a cycle where `cmp_valid` and `cmp_ready` are both high, and a held completion is not lost or duplicated.
- R2: Entries leave in arrival order. Reading with `rd_sel`=0 returns the head byte count. Reading with `rd_sel`=1 returns the head status: error code in bits 7:0, early flag in bit 8, zeros above.
- R3: The head entry is removed on the read that completes the pair of both words, in either order. Repeating a read of the same word does not remove it.
- R4: `fill_level` gives the number of stored entries in its low bits. `resp_empty` is high exactly at level 0 and `resp_full` is high exactly at level DEPTH. Both flags and the level are updated on the clock edge after an accepted push or pop.
- R5: A read while the FIFO is empty returns 0 for either word and leaves the level at 0.
- R6: An accepted completion whose control bit 14 is 1 sets `irq_pending` on the next edge.
- R7: An accepted completion with the early flag set and control bit 15 set sets `irq_pending`.
- R8: An accepted completion whose error code has a bit in common with control bits 23:16 sets `irq_pending`. Other control bits have no effect on the flag.
- R9: `irq_clr` clears `irq_pending` on the next edge. A set in the same cycle takes priority over the clear.
- R10: `irq` is high when `irq_pending` is high and `glob_irq_en` is high, and is low otherwise.
- R11: With `stop_err_en` high, an accepted completion with a nonzero error code sets `halted_err`. With `stop_early_en` high, an accepted early termination sets `halted_early`. `halt_clr` clears both flags, and a set wins over a clear.
- R12: A push and a pop in the same cycle leave `fill_level` unchanged and keep both entries in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_valid | input | 1 | Completion offered by the data mover |
| cmp_ready | output | 1 | Completion accepted (FIFO not full) |
| cmp_bytes | input | BYTES_W | Bytes transferred by the descriptor |
| cmp_err | input | 8 | Error code of the descriptor |
| cmp_early | input | 1 | Descriptor ended early |
| cmp_ctrl | input | 32 | Control word of the completing descriptor |
| rd_en | input | 1 | Host read strobe for the response window |
| rd_sel | input | 1 | 0: byte-count word, 1: status word |
| rd_data | output | 32 | Read data of the selected head word |
| fill_level | output | 16 | Number of stored responses |
| resp_empty | output | 1 | FIFO empty |
| resp_full | output | 1 | FIFO full |
| glob_irq_en | input | 1 | Global interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear for the pending flag |
| stop_err_en | input | 1 | Halt on error |
| stop_early_en | input | 1 | Halt on early termination |
| halt_clr | input | 1 | Clears both halt flags |
| irq_pending | output | 1 | Interrupt-pending status |
| irq | output | 1 | Interrupt line |
| halted_err | output | 1 | Halted because of an error |
| halted_early | output | 1 | Halted because of early termination |

## Verification
The bench sweeps every combination of the two interrupt request bits and the early flag against several error codes and masks. A design that ORs the error code without the mask, or ignores the early flag, raises spurious interrupts there. It fills the queue to the brim and holds a completion against it. A design with the wrong full test overwrites the oldest entry or loses the held completion. Reads of one word repeated, reads in reverse order, reads of an empty queue, and a push that coincides with a pop are all exercised. A design that pops on a single read, underflows its pointers, or miscounts the level then returns the wrong word or level.

// File: rtl/dma_resp_pkg.sv
package dma_resp_pkg;
   localparam int ERR_W         = 8;
   localparam int CTL_W         = 32;
   localparam int WORD_W        = 32;
   localparam int LVL_W         = 16;
   // control word bit positions decoded by this block
   localparam int CTL_DONE_IRQ  = 14;
   localparam int CTL_EARLY_IRQ = 15;
   localparam int CTL_EMASK_LO  = 16;
   // status word layout
   localparam int ST_EARLY_BIT  = 8;
endpackage

// File: rtl/resp_fifo.sv
module resp_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 41,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     din,
   input  logic             pop,
   output logic [W-1:0]     dout,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr, wnext, rnext;
   logic             do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wnext = wptr + 1'b1;
         assign rnext = rptr + 1'b1;
      end else begin : g_wrap
         assign wnext = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rnext = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wnext;
         if (do_pop)  rptr <= rnext;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/resp_irq_ctl.sv
module resp_irq_ctl
   import dma_resp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt,
   input  logic [CTL_W-1:0] ctrl,
   input  logic [ERR_W-1:0] err,
   input  logic             early,
   input  logic             irq_clr,
   input  logic             halt_clr,
   input  logic             stop_err_en,
   input  logic             stop_early_en,
   output logic             pending,
   output logic             halted_err,
   output logic             halted_early
);
   logic             want_done, want_early, want_err, raise;
   logic [ERR_W-1:0] emask;

   assign emask      = ctrl[CTL_EMASK_LO +: ERR_W];
   assign want_done  = ctrl[CTL_DONE_IRQ];
   assign want_early = ctrl[CTL_EARLY_IRQ] && early;
   assign want_err   = |(err & emask);
   assign raise      = evt && (want_done || want_early || want_err);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending      <= 1'b0;
         halted_err   <= 1'b0;
         halted_early <= 1'b0;
      end else begin
         if (raise)        pending <= 1'b1;
         else if (irq_clr) pending <= 1'b0;

         if (evt && stop_err_en && (err != '0)) halted_err <= 1'b1;
         else if (halt_clr)                     halted_err <= 1'b0;

         if (evt && stop_early_en && early) halted_early <= 1'b1;
         else if (halt_clr)                 halted_early <= 1'b0;
      end
   end
endmodule

// File: rtl/resp_read_port.sv
module resp_read_port
   import dma_resp_pkg::*;
#(
   parameter int BYTES_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              rd_sel,
   input  logic              empty,
   input  logic [BYTES_W-1:0] head_bytes,
   input  logic [ERR_W-1:0]  head_err,
   input  logic              head_early,
   output logic [WORD_W-1:0] rd_data,
   output logic              pop
);
   logic got_bytes, got_stat, hit_bytes, hit_stat;

   assign hit_bytes = rd_en && !empty && !rd_sel;
   assign hit_stat  = rd_en && !empty &&  rd_sel;
   assign pop       = (hit_bytes && got_stat) || (hit_stat && got_bytes);

   always_comb begin
      rd_data = '0;
      if (!empty) begin
         if (rd_sel) begin
            rd_data[ERR_W-1:0]   = head_err;
            rd_data[ST_EARLY_BIT] = head_early;
         end else begin
            rd_data[BYTES_W-1:0] = head_bytes;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         got_bytes <= 1'b0;
         got_stat  <= 1'b0;
      end else if (pop) begin
         got_bytes <= 1'b0;
         got_stat  <= 1'b0;
      end else begin
         if (hit_bytes) got_bytes <= 1'b1;
         if (hit_stat)  got_stat  <= 1'b1;
      end
   end
endmodule

// File: rtl/dma_resp_queue.sv
module dma_resp_queue
   import dma_resp_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int BYTES_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmp_valid,
   output logic               cmp_ready,
   input  logic [BYTES_W-1:0] cmp_bytes,
   input  logic [7:0]         cmp_err,
   input  logic               cmp_early,
   input  logic [31:0]        cmp_ctrl,
   input  logic               rd_en,
   input  logic               rd_sel,
   output logic [31:0]        rd_data,
   output logic [15:0]        fill_level,
   output logic               resp_empty,
   output logic               resp_full,
   input  logic               glob_irq_en,
   input  logic               irq_clr,
   input  logic               stop_err_en,
   input  logic               stop_early_en,
   input  logic               halt_clr,
   output logic               irq_pending,
   output logic               irq,
   output logic               halted_err,
   output logic               halted_early
);
   localparam int ENT_W = BYTES_W + ERR_W + 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("dma_resp_queue: DEPTH must be at least 2");
      end
      if (CNT_W > LVL_W) begin : g_bad_level
         $error("dma_resp_queue: DEPTH does not fit the level field");
      end
      if (BYTES_W < 1 || BYTES_W > WORD_W) begin : g_bad_bytes
         $error("dma_resp_queue: BYTES_W must be 1..32");
      end
   endgenerate

   logic             accept, pop;
   logic [ENT_W-1:0] wr_ent, head_ent;
   logic [CNT_W-1:0] count;

   assign cmp_ready = !resp_full;
   assign accept    = cmp_valid && cmp_ready;
   assign wr_ent    = {cmp_bytes, cmp_early, cmp_err};

   resp_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (accept),
      .din   (wr_ent),
      .pop   (pop),
      .dout  (head_ent),
      .count (count),
      .full  (resp_full),
      .empty (resp_empty)
   );

   resp_read_port #(.BYTES_W(BYTES_W)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (rd_en),
      .rd_sel     (rd_sel),
      .empty      (resp_empty),
      .head_bytes (head_ent[ENT_W-1 -: BYTES_W]),
      .head_err   (head_ent[ERR_W-1:0]),
      .head_early (head_ent[ERR_W]),
      .rd_data    (rd_data),
      .pop        (pop)
   );

   resp_irq_ctl u_irq (
      .clk           (clk),
      .rst_n         (rst_n),
      .evt           (accept),
      .ctrl          (cmp_ctrl),
      .err           (cmp_err),
      .early         (cmp_early),
      .irq_clr       (irq_clr),
      .halt_clr      (halt_clr),
      .stop_err_en   (stop_err_en),
      .stop_early_en (stop_early_en),
      .pending       (irq_pending),
      .halted_err    (halted_err),
      .halted_early  (halted_early)
   );

   assign fill_level = LVL_W'(count);
   assign irq        = irq_pending && glob_irq_en;
endmodule

// File: rtl/dma_resp_queue_chk.sv
module dma_resp_queue_chk #(
   parameter int DEPTH = 16
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cmp_valid,
   input logic        cmp_ready,
   input logic        rd_en,
   input logic [31:0] rd_data,
   input logic [15:0] fill_level,
   input logic        resp_empty,
   input logic        resp_full,
   input logic        irq_clr,
   input logic        irq_pending,
   input logic        halted_err,
   input logic        halted_early
);
   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      resp_full |-> !cmp_ready);

   assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_level <= 16'(DEPTH)) && (resp_empty == (fill_level == 16'd0)));

   assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && resp_empty) |-> (rd_data == 32'd0));

   assert_idle_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_valid && !rd_en) |=> $stable(fill_level));

   assert_pending_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pending) |-> $past(cmp_valid && cmp_ready));

   assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !cmp_valid) |=> !irq_pending);

   assert_halt_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(halted_err) || $rose(halted_early)) |-> $past(cmp_valid && cmp_ready));
endmodule

bind dma_resp_queue dma_resp_queue_chk #(.DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmp_valid    (cmp_valid),
   .cmp_ready    (cmp_ready),
   .rd_en        (rd_en),
   .rd_data      (rd_data),
   .fill_level   (fill_level),
   .resp_empty   (resp_empty),
   .resp_full    (resp_full),
   .irq_clr      (irq_clr),
   .irq_pending  (irq_pending),
   .halted_err   (halted_err),
   .halted_early (halted_early)
);

// File: tb/dma_resp_queue_test.sv
`timescale 1ns/1ps
module dma_resp_queue_test;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmp_valid = 1'b0;
   logic        cmp_ready;
   logic [31:0] cmp_bytes = '0;
   logic [7:0]  cmp_err = '0;
   logic        cmp_early = 1'b0;
   logic [31:0] cmp_ctrl = '0;
   logic        rd_en = 1'b0;
   logic        rd_sel = 1'b0;
   logic [31:0] rd_data;
   logic [15:0] fill_level;
   logic        resp_empty, resp_full;
   logic        glob_irq_en = 1'b0;
   logic        irq_clr = 1'b0;
   logic        stop_err_en = 1'b0;
   logic        stop_early_en = 1'b0;
   logic        halt_clr = 1'b0;
   logic        irq_pending, irq, halted_err, halted_early;

   int n_vec = 0;
   int n_bad = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   dma_resp_queue #(.DEPTH(DEPTH), .BYTES_W(32)) uut (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
      .cmp_bytes(cmp_bytes), .cmp_err(cmp_err), .cmp_early(cmp_early),
      .cmp_ctrl(cmp_ctrl), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
      .fill_level(fill_level), .resp_empty(resp_empty), .resp_full(resp_full),
      .glob_irq_en(glob_irq_en), .irq_clr(irq_clr), .stop_err_en(stop_err_en),
      .stop_early_en(stop_early_en), .halt_clr(halt_clr),
      .irq_pending(irq_pending), .irq(irq), .halted_err(halted_err),
      .halted_early(halted_early)
   );

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
         summary();
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic push_one(logic [31:0] b, logic [7:0] e, logic ea, logic [31:0] c);
      @(negedge clk);
      cmp_valid = 1'b1; cmp_bytes = b; cmp_err = e; cmp_early = ea; cmp_ctrl = c;
      @(negedge clk);
      cmp_valid = 1'b0; cmp_ctrl = '0; cmp_err = '0; cmp_early = 1'b0;
   endtask

   task automatic read_word(logic sel, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_sel = sel;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   function automatic logic [31:0] stat_of(logic [7:0] e, logic ea);
      return {23'd0, ea, e};
   endfunction

   logic [31:0] d;
   logic [7:0]  errs  [4] = '{8'h00, 8'h01, 8'h80, 8'h5A};
   logic [7:0]  masks [4] = '{8'h00, 8'hFF, 8'h01, 8'hA5};

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R4 reset level", 32'(fill_level), 0);
      chk("R4 reset empty", 32'(resp_empty), 1);
      chk("R1 reset ready", 32'(cmp_ready), 1);
      chk("R10 reset irq", 32'(irq), 0);
      chk("R6 reset pending", 32'(irq_pending), 0);

      // R5: empty reads
      read_word(1'b0, d); chk("R5 empty bytes word", d, 0);
      read_word(1'b1, d); chk("R5 empty status word", d, 0);
      chk("R5 level after empty reads", 32'(fill_level), 0);

      // fill to the brim, R4 level tracking
      for (int i = 0; i < DEPTH; i++) begin
         push_one(32'(100 + i), 8'(i + 1), i[0], 32'd0);
         chk("R4 level on fill", 32'(fill_level), 32'(i + 1));
      end
      chk("R4 full flag", 32'(resp_full), 1);
      chk("R1 ready low when full", 32'(cmp_ready), 0);
      // hold a completion against the full queue
      @(negedge clk);
      cmp_valid = 1'b1; cmp_bytes = 32'd999; cmp_err = 8'h11;
      @(negedge clk);
      @(negedge clk);
      chk("R1 held completion not stored", 32'(fill_level), DEPTH);

      // R3: bytes then bytes again then status
      read_word(1'b0, d); chk("R2 head bytes", d, 100);
      read_word(1'b0, d); chk("R3 repeated read keeps entry", 32'(fill_level), DEPTH);
      // queue still full, held completion still waiting
      chk("R1 still stalled", 32'(cmp_ready), 0);
      read_word(1'b1, d); chk("R2 head status", d, stat_of(8'd1, 1'b0));
      // pop frees a slot; the held completion goes in on the next edge
      @(negedge clk);
      cmp_valid = 1'b0; cmp_err = '0;
      chk("R1 held completion accepted once", 32'(fill_level), DEPTH);

      // R3 reverse order: status first, then bytes
      read_word(1'b1, d); chk("R2 second status", d, stat_of(8'd2, 1'b1));
      chk("R3 status alone keeps entry", 32'(fill_level), DEPTH);
      read_word(1'b0, d); chk("R2 second bytes", d, 101);
      chk("R3 pop after pair", 32'(fill_level), DEPTH - 1);

      // R12: simultaneous push and pop
      read_word(1'b0, d); chk("R2 third bytes", d, 102);
      @(negedge clk);
      cmp_valid = 1'b1; cmp_bytes = 32'd200; cmp_err = 8'h00; cmp_early = 1'b0;
      rd_en = 1'b1; rd_sel = 1'b1;
      #1 chk("R2 third status", rd_data, stat_of(8'd3, 1'b0));
      @(negedge clk);
      cmp_valid = 1'b0; rd_en = 1'b0;
      chk("R12 level unchanged", 32'(fill_level), DEPTH - 1);

      // drain in order: 103, 999, 200
      read_word(1'b0, d); chk("R2 order 103", d, 103);
      read_word(1'b1, d); chk("R2 status 4", d, stat_of(8'd4, 1'b1));
      read_word(1'b0, d); chk("R2 order held entry", d, 999);
      read_word(1'b1, d); chk("R2 held status", d, stat_of(8'h11, 1'b0));
      read_word(1'b0, d); chk("R12 order pushed entry", d, 200);
      read_word(1'b1, d);
      chk("R4 empty after drain", 32'(resp_empty), 1);
      @(negedge clk); irq_clr = 1'b1; halt_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0; halt_clr = 1'b0;

      // interrupt and halt sweep: R6 R7 R8 R10 R11
      for (int rq = 0; rq < 4; rq++)
         for (int ea = 0; ea < 2; ea++)
            for (int ei = 0; ei < 4; ei++)
               for (int mi = 0; mi < 4; mi++) begin
                  automatic int vix = ((rq * 2 + ea) * 4 + ei) * 4 + mi;
                  automatic logic [31:0] c = {8'h00, masks[mi], rq[1], rq[0], 14'h3FFF};
                  automatic logic ex_p = rq[0] || (rq[1] && ea[0]) || ((errs[ei] & masks[mi]) != 0);
                  automatic logic en_e = vix[0];
                  automatic logic en_x = vix[1];
                  glob_irq_en = vix[2];
                  stop_err_en = en_e; stop_early_en = en_x;
                  push_one(32'(vix), errs[ei], ea[0], c);
                  chk("R6 R7 R8 pending", 32'(irq_pending), 32'(ex_p));
                  chk("R10 gated line", 32'(irq), 32'(ex_p && vix[2]));
                  chk("R11 halt on error", 32'(halted_err), 32'(en_e && errs[ei] != 0));
                  chk("R11 halt on early", 32'(halted_early), 32'(en_x && ea[0]));
                  read_word(1'b0, d); chk("R2 sweep bytes", d, 32'(vix));
                  read_word(1'b1, d); chk("R2 sweep status", d, stat_of(errs[ei], ea[0]));
                  @(negedge clk); irq_clr = 1'b1; halt_clr = 1'b1;
                  @(negedge clk); irq_clr = 1'b0; halt_clr = 1'b0;
                  chk("R9 pending cleared", 32'(irq_pending), 0);
                  chk("R11 halt cleared", 32'(halted_err | halted_early), 0);
               end

      // R9: set wins over clear in the same cycle
      stop_err_en = 1'b1;
      @(negedge clk);
      cmp_valid = 1'b1; cmp_bytes = 32'd7; cmp_err = 8'h02; cmp_ctrl = 32'h0000_4000;
      irq_clr = 1'b1; halt_clr = 1'b1;
      @(negedge clk);
      cmp_valid = 1'b0; irq_clr = 1'b0; halt_clr = 1'b0; cmp_ctrl = '0; cmp_err = '0;
      chk("R9 set beats clear", 32'(irq_pending), 1);
      chk("R11 set beats clear", 32'(halted_err), 1);
      glob_irq_en = 1'b1; #1;
      chk("R10 enable raises line", 32'(irq), 1);
      glob_irq_en = 1'b0; #1;
      chk("R10 disable drops line", 32'(irq), 0);

      summary();
   end
endmodule